// File: doc/BRIEF.md
# Priority Vectored Interrupt Controller

This block gathers thirteen level-sensitive interrupt inputs, numbered 1 to 13, and turns them into one prioritized request for a processor. The request is a 3-bit level and an 8-bit vector. Each input is sampled every clock into a pending register. An input can win only when it is pending and its mask bit is clear. Among those inputs, the one whose control byte carries the largest 5-bit level-and-priority value wins. The winner's level and vector are registered and presented to the processor.

Each source has its own 8-bit control byte. Bit 7 selects an autovector, bits 4:2 hold the level and bits 1:0 hold a sub-priority. When the autovector bit is clear, the vector comes from a programmable byte for three dedicated sources. Every other source gets a fixed default vector. The register bus is a plain write strobe with address and data, and read data is returned combinationally from the address.

The output stage is a two-state machine. In `ST_QUIET` no request is raised and both level and vector read zero. In `ST_ACTIVE` a request is raised. The machine has four transitions: quiet-to-active when a qualifying winner appears, active-to-quiet when none remains, active-to-active when a winner persists (its level or vector may change), and quiet-to-quiet otherwise.

Top module: `prio_vec_intc`

## Requirements
- R1: The pending bit of source i equals the `src_in` bit i-1 one clock earlier. The pending register reads at address 0x3A with source i in bit i; bits 0, 14 and 15 read 0.
- R2: A source takes part in arbitration only when it is pending and its mask bit is 0. The mask is read and written at 0x36 with source i in bit i, and 1 means masked. Bits 0, 14 and 15 are not stored and read 0.
- R3: The winner is the participating source with the largest control bits 4:0. On equal values the lowest-numbered source wins.
- R4: If no source takes part, or the winning 5-bit value is below 4, `irq_req` is 0 and both `irq_level` and `irq_vector` are 0.
- R5: With a qualifying winner, `irq_req` is 1 and `irq_level` equals the winner's control bits 4:2.
- R6: If the winner's control bit 7 is 1, `irq_vector` is 24 plus the level.
- R7: If the winner's control bit 7 is 0, the vector is taken as follows: source 8 uses the byte at 0x44, source 12 uses the byte at 0x48, source 13 uses the byte at 0x4C, and any other source gives 0x0F.
- R8: After reset the registers hold these values. Mask reads 0x3FFE and pending reads 0. Control bytes for sources 1 to 7 are 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x1C. Source 8 is 0x1C, sources 9 to 11 are 0x80, and sources 12 and 13 are 0x00. The byte at 0x44 is 0x0F, the bytes at 0x48 and 0x4C are 0x00, and all outputs are 0.
- R9: The control byte of source i is at address 0x13+i and reads back the full byte written (`wr_data[7:0]`). A write to 0x3A has no effect, and reads of unmapped addresses return 0.
- R10: The outputs are registered. A change on `src_in` shows at the outputs after the second rising edge, and a register write shows after the edge that follows the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 13 | Interrupt inputs; bit i-1 is source i |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr` |
| irq_req | output | 1 | Request raised (state `ST_ACTIVE`) |
| irq_level | output | 3 | Requested level |
| irq_vector | output | 8 | Requested vector |

## Verification
A register write can land on the same clock edge as a change of the interrupt inputs. The arbiter then has to see both the new pending set and the new control or mask value at once. The random phase provokes this on every iteration: the bench drives a fresh input pattern together with a random write to a control, mask, vector or pending address. It then compares the registered outputs one edge later with a reference model that has applied both updates. Directed cases cover ties between sources, winners below level 1, autovectors and the three dedicated vector bytes.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int NUM_SRC  = 13;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 16;
    localparam int CTL_W    = 8;
    localparam int LVL_W    = 3;
    localparam int PRI_W    = 2;
    localparam int KEY_W    = LVL_W + PRI_W;
    localparam int VEC_W    = 8;
    localparam int IDX_W    = $clog2(NUM_SRC + 1);

    localparam int CTL_BASE = 'h14;
    localparam int MASK_ADR = 'h36;
    localparam int PEND_ADR = 'h3A;
    localparam int SWV_ADR  = 'h44;
    localparam int VA_ADR   = 'h48;
    localparam int VB_ADR   = 'h4C;

    localparam int SWV_SRC  = 8;
    localparam int VA_SRC   = 12;
    localparam int VB_SRC   = 13;

    localparam int AUTO_BASE   = 24;
    localparam int DEFAULT_VEC = 'h0F;
    localparam int KEY_MIN     = 4;

    typedef enum logic {
        ST_QUIET  = 1'b0,
        ST_ACTIVE = 1'b1
    } out_state_t;

    function automatic logic [CTL_W-1:0] ctl_reset(input int idx);
        if (idx >= 1 && idx <= 7)
            return CTL_W'(idx * 4);
        else if (idx == 8)
            return CTL_W'('h1C);
        else if (idx >= 9 && idx <= 11)
            return CTL_W'('h80);
        else
            return '0;
    endfunction

endpackage

// File: rtl/intc_regs.sv
module intc_regs
    import intc_pkg::*;
#(
    parameter int NSRC = NUM_SRC,
    parameter int AW   = ADDR_W,
    parameter int DW   = DATA_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NSRC-1:0]           src_in,
    input  logic                      wr_en,
    input  logic [AW-1:0]             addr,
    input  logic [DW-1:0]             wr_data,
    output logic [DW-1:0]             rd_data,
    output logic [NSRC:1]             pend,
    output logic [NSRC:1]             mask,
    output logic [NSRC:1][CTL_W-1:0]  ctl,
    output logic [VEC_W-1:0]          swvec,
    output logic [VEC_W-1:0]          vec_a,
    output logic [VEC_W-1:0]          vec_b
);

    localparam logic [AW-1:0] A_MASK = AW'(MASK_ADR);
    localparam logic [AW-1:0] A_SWV  = AW'(SWV_ADR);
    localparam logic [AW-1:0] A_VA   = AW'(VA_ADR);
    localparam logic [AW-1:0] A_VB   = AW'(VB_ADR);
    localparam logic [AW-1:0] A_PEND = AW'(PEND_ADR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend  <= '0;
            mask  <= '1;
            swvec <= VEC_W'(DEFAULT_VEC);
            vec_a <= '0;
            vec_b <= '0;
            for (int i = 1; i <= NSRC; i++)
                ctl[i] <= ctl_reset(i);
        end else begin
            pend <= src_in;
            if (wr_en) begin
                if (addr == A_MASK) mask  <= wr_data[NSRC:1];
                if (addr == A_SWV)  swvec <= wr_data[VEC_W-1:0];
                if (addr == A_VA)   vec_a <= wr_data[VEC_W-1:0];
                if (addr == A_VB)   vec_b <= wr_data[VEC_W-1:0];
                for (int i = 1; i <= NSRC; i++)
                    if (addr == AW'(CTL_BASE + i - 1))
                        ctl[i] <= wr_data[CTL_W-1:0];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (addr == A_MASK) rd_data = DW'({mask, 1'b0});
        if (addr == A_PEND) rd_data = DW'({pend, 1'b0});
        if (addr == A_SWV)  rd_data = DW'(swvec);
        if (addr == A_VA)   rd_data = DW'(vec_a);
        if (addr == A_VB)   rd_data = DW'(vec_b);
        for (int i = 1; i <= NSRC; i++)
            if (addr == AW'(CTL_BASE + i - 1))
                rd_data = DW'(ctl[i]);
    end

    // R9: a write aimed at the pending address leaves pending following the inputs
    p_pend_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_PEND) |=> (pend == $past(src_in)));

endmodule

// File: rtl/intc_arb.sv
module intc_arb
    import intc_pkg::*;
#(
    parameter int NSRC = NUM_SRC
) (
    input  logic [NSRC:1]             pend,
    input  logic [NSRC:1]             mask,
    input  logic [NSRC:1][CTL_W-1:0]  ctl,
    output logic                      win_valid,
    output logic [IDX_W-1:0]          win_idx,
    output logic [CTL_W-1:0]          win_ctl
);

    logic [KEY_W-1:0] best_key;

    // Walk upward with a strict compare so equal keys keep the lower source.
    always_comb begin
        best_key = '0;
        win_idx  = '0;
        win_ctl  = '0;
        for (int i = 1; i <= NSRC; i++) begin
            if (pend[i] && !mask[i] && (ctl[i][KEY_W-1:0] > best_key)) begin
                best_key = ctl[i][KEY_W-1:0];
                win_idx  = IDX_W'(i);
                win_ctl  = ctl[i];
            end
        end
        win_valid = (best_key >= KEY_W'(KEY_MIN));
    end

endmodule

// File: rtl/intc_vecsel.sv
module intc_vecsel
    import intc_pkg::*;
#(
    parameter int SWV_IDX = SWV_SRC,
    parameter int VA_IDX  = VA_SRC,
    parameter int VB_IDX  = VB_SRC
) (
    input  logic                  win_valid,
    input  logic [IDX_W-1:0]      win_idx,
    input  logic [CTL_W-1:0]      win_ctl,
    input  logic [VEC_W-1:0]      swvec,
    input  logic [VEC_W-1:0]      vec_a,
    input  logic [VEC_W-1:0]      vec_b,
    output logic [LVL_W-1:0]      nxt_level,
    output logic [VEC_W-1:0]      nxt_vector
);

    localparam int AUTO_BIT = CTL_W - 1;

    always_comb begin
        nxt_level  = '0;
        nxt_vector = '0;
        if (win_valid) begin
            nxt_level = win_ctl[KEY_W-1:PRI_W];
            if (win_ctl[AUTO_BIT])
                nxt_vector = VEC_W'(AUTO_BASE) + VEC_W'(nxt_level);
            else if (win_idx == IDX_W'(SWV_IDX))
                nxt_vector = swvec;
            else if (win_idx == IDX_W'(VA_IDX))
                nxt_vector = vec_a;
            else if (win_idx == IDX_W'(VB_IDX))
                nxt_vector = vec_b;
            else
                nxt_vector = VEC_W'(DEFAULT_VEC);
        end
    end

endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
    import intc_pkg::*;
#(
    parameter int NSRC = NUM_SRC,
    parameter int AW   = ADDR_W,
    parameter int DW   = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_in,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wr_data,
    output logic [DW-1:0]     rd_data,
    output logic              irq_req,
    output logic [LVL_W-1:0]  irq_level,
    output logic [VEC_W-1:0]  irq_vector
);

    logic [NSRC:1]             pend;
    logic [NSRC:1]             mask;
    logic [NSRC:1][CTL_W-1:0]  ctl;
    logic [VEC_W-1:0]          swvec, vec_a, vec_b;
    logic                      win_valid;
    logic [IDX_W-1:0]          win_idx;
    logic [CTL_W-1:0]          win_ctl;
    logic [LVL_W-1:0]          nxt_level;
    logic [VEC_W-1:0]          nxt_vector;
    out_state_t                st, nxt_st;

    intc_regs #(.NSRC(NSRC), .AW(AW), .DW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_in  (src_in),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .pend    (pend),
        .mask    (mask),
        .ctl     (ctl),
        .swvec   (swvec),
        .vec_a   (vec_a),
        .vec_b   (vec_b)
    );

    intc_arb #(.NSRC(NSRC)) u_arb (
        .pend      (pend),
        .mask      (mask),
        .ctl       (ctl),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_ctl   (win_ctl)
    );

    intc_vecsel u_vecsel (
        .win_valid  (win_valid),
        .win_idx    (win_idx),
        .win_ctl    (win_ctl),
        .swvec      (swvec),
        .vec_a      (vec_a),
        .vec_b      (vec_b),
        .nxt_level  (nxt_level),
        .nxt_vector (nxt_vector)
    );

    always_comb begin
        nxt_st = st;
        unique case (st)
            ST_QUIET:  nxt_st = win_valid ? ST_ACTIVE : ST_QUIET;
            ST_ACTIVE: nxt_st = win_valid ? ST_ACTIVE : ST_QUIET;
            default:   nxt_st = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_QUIET;
        else        st <= nxt_st;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_level  <= '0;
            irq_vector <= '0;
        end else begin
            irq_level  <= nxt_level;
            irq_vector <= nxt_vector;
        end
    end

    assign irq_req = (st == ST_ACTIVE);

    logic [NSRC:0] act_ext;
    assign act_ext = {pend & ~mask, 1'b0};

    // R4: a quiet state carries zero level and vector
    p_quiet_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (irq_level == '0 && irq_vector == '0));

    // R5: a raised request always carries a nonzero level
    p_req_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_level != '0));

    // R2: a request needs an unmasked pending source one cycle earlier
    p_req_needs_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(|(pend & ~mask)));

    // R3: the chosen source is pending and unmasked
    p_winner_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> act_ext[win_idx]);

    // R6: autovector winner gives 24 plus the level
    p_autovec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && $past(win_ctl[CTL_W-1])) |->
        (irq_vector == VEC_W'(AUTO_BASE) + VEC_W'(irq_level)));

endmodule

// File: tb/tb_prio_vec_intc.sv
module tb_prio_vec_intc;
    import intc_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [12:0]       src_in = '0;
    logic              wr_en = 1'b0;
    logic [7:0]        addr = '0;
    logic [15:0]       wr_data = '0;
    logic [15:0]       rd_data;
    logic              irq_req;
    logic [2:0]        irq_level;
    logic [7:0]        irq_vector;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [7:0]  m_ctl [1:13];
    logic [13:1] m_mask;
    logic [7:0]  m_swv, m_va, m_vb;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_vec_intc dut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .irq_req(irq_req), .irq_level(irq_level), .irq_vector(irq_vector)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    function automatic void model_reset();
        for (int i = 1; i <= 13; i++) begin
            if (i <= 7) m_ctl[i] = 8'(i * 4);
            else if (i == 8) m_ctl[i] = 8'h1C;
            else if (i <= 11) m_ctl[i] = 8'h80;
            else m_ctl[i] = 8'h00;
        end
        m_mask = '1;
        m_swv = 8'h0F;
        m_va = 8'h00;
        m_vb = 8'h00;
    endfunction

    function automatic void model_write(input logic [7:0] a, input logic [15:0] d);
        if (a >= 8'h14 && a <= 8'h20) m_ctl[a - 8'h13] = d[7:0];
        if (a == 8'h36) m_mask = d[13:1];
        if (a == 8'h44) m_swv = d[7:0];
        if (a == 8'h48) m_va = d[7:0];
        if (a == 8'h4C) m_vb = d[7:0];
    endfunction

    function automatic logic [11:0] model_out(input logic [12:0] s);
        int best, who;
        logic [2:0] lv;
        logic [7:0] vc;
        best = 0; who = 0;
        for (int i = 1; i <= 13; i++)
            if (s[i-1] && !m_mask[i] && int'(m_ctl[i][4:0]) > best) begin
                best = int'(m_ctl[i][4:0]);
                who = i;
            end
        if (best < 4) return 12'h0;
        lv = m_ctl[who][4:2];
        if (m_ctl[who][7]) vc = 8'd24 + 8'(lv);
        else if (who == 8) vc = m_swv;
        else if (who == 12) vc = m_va;
        else if (who == 13) vc = m_vb;
        else vc = 8'h0F;
        return {1'b1, lv, vc};
    endfunction

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        model_write(a, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic check_out(input string req);
        logic [11:0] e;
        e = model_out(src_in);
        chk(req, 16'(irq_req), 16'(e[11]));
        chk(req, 16'(irq_level), 16'(e[10:8]));
        chk(req, 16'(irq_vector), 16'(e[7:0]));
    endtask

    task automatic apply_src(input logic [12:0] s);
        src_in = s;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [7:0] ra;
        void'($urandom(32'd12345));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: reset values
        rd(8'h36, v); chk("R8 mask", v, 16'h3FFE);
        rd(8'h3A, v); chk("R8 pending", v, 16'h0000);
        for (int i = 1; i <= 13; i++) begin
            rd(8'(8'h13 + i), v); chk("R8 ctl", v, 16'(m_ctl[i]));
        end
        rd(8'h44, v); chk("R8 swvec", v, 16'h000F);
        rd(8'h48, v); chk("R8 vec12", v, 16'h0000);
        rd(8'h4C, v); chk("R8 vec13", v, 16'h0000);
        chk("R8 req", 16'(irq_req), 16'h0);

        // R2: all masked after reset, so no request
        apply_src(13'h1FFF);
        check_out("R2 masked");

        // R1 / R9: pending follows inputs, write to pending ignored
        wr(8'h3A, 16'h0000);
        @(negedge clk);
        rd(8'h3A, v); chk("R9 pending write ignored", v, 16'h3FFE);
        src_in = 13'h0A5A;
        @(negedge clk);
        rd(8'h3A, v); chk("R1 pending follows", v, {2'b0, 13'h0A5A, 1'b0});
        rd(8'h00, v); chk("R9 unmapped read", v, 16'h0000);
        wr(8'h36, 16'hFFFF);
        rd(8'h36, v); chk("R2 mask unstored bits", v, 16'h3FFE);

        // R3 / R7: tie between source 8 and 12, lower wins with sw vector
        wr(8'h1B, 16'h0014);
        wr(8'h1F, 16'h0014);
        wr(8'h44, 16'h0066);
        wr(8'h48, 16'h0055);
        wr(8'h36, 16'h2EFE);
        apply_src(13'h0880);
        check_out("R3 tie lowest wins");
        chk("R7 swvec vector", 16'(irq_vector), 16'h0066);
        // R7: only source 12 active
        apply_src(13'h0800);
        check_out("R7 vec12");
        chk("R7 vec12 value", 16'(irq_vector), 16'h0055);
        // R7: other source without autovector gives 0x0F
        wr(8'h36, 16'h3FFA);
        wr(8'h15, 16'h0018);
        apply_src(13'h0002);
        check_out("R7 default vector");
        chk("R5 level", 16'(irq_level), 16'h0006);
        // R4: key below 4
        wr(8'h15, 16'h0003);
        @(negedge clk);
        check_out("R4 below minimum");
        chk("R4 req low", 16'(irq_req), 16'h0);
        // R6: autovector
        wr(8'h15, 16'h009D);
        @(negedge clk);
        check_out("R6 autovector");
        chk("R6 value", 16'(irq_vector), 16'd31);
        // R10: write at same edge as source change, outputs one edge later
        src_in = 13'h0000;
        @(negedge clk);
        chk("R10 src latency", 16'(irq_req), 16'h1);
        @(negedge clk);
        check_out("R10 src cleared");

        // random phase: inputs and register writes collide each cycle
        for (int it = 0; it < 400; it++) begin
            logic [3:0] pick;
            src_in = 13'($urandom);
            pick = 4'($urandom_range(0, 15));
            if (pick <= 12) ra = 8'(8'h14 + pick);
            else if (pick == 13) ra = 8'h36;
            else if (pick == 14) ra = ($urandom_range(0, 1) != 0) ? 8'h3A : 8'h44;
            else ra = ($urandom_range(0, 1) != 0) ? 8'h48 : 8'h4C;
            wr(ra, 16'($urandom));
            @(negedge clk);
            check_out("R3 R5 R6 R7 R10 random");
            rd(8'h3A, v); chk("R1 random pending", v, {2'b0, src_in, 1'b0});
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule